// File: doc/BRIEF.md
# Power-Fail Supervisor with SRAM Write Guard

This block is a clocked sequencer that sits between a host and an external battery-backed SRAM. It watches three inputs. The first is a digital supply-fail flag from an external comparator. The second is a supply-switchover flag that goes high when the part runs from backup. The third is an active-low push-button. From these it drives a reset output, an optional power-fail interrupt and a guarded SRAM chip-enable. All delays are whole clock cycles, derived from a clock-rate parameter and microsecond parameters.

When the supply fails, the block first raises the interrupt, if software has enabled it. After a fixed grace period it blocks the SRAM chip-enable and asserts reset, so the host has time to finish its work. An SRAM cycle that is under way when the grace period ends is allowed to complete. When power returns, reset and write protection stay on for a long time-out. A push-button press that stays low long enough starts the same time-out. The open-drain reset and interrupt pins are modelled as active-high pull-down enables: 1 means the pin is driven low, and 0 means it is released.

Top module: `pwr_guard`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `rst_pull_o` is 1, `sram_ce_n_o` is 1 whatever `host_ce_n_i` is, and `irq_pull_o` is 0.
- R2: Once `fail_i` is low and `swover_i` is low, `rst_pull_o` and the SRAM block stay active for RST_US×CLK_MHZ cycles (plus synchronizer latency) and are then released.
- R3: Once `fail_i` goes high, `rst_pull_o` stays 0 and `sram_ce_n_o` follows `host_ce_n_i` for WP_US×CLK_MHZ cycles. After that, `rst_pull_o` becomes 1 and `sram_ce_n_o` is held at 1.
- R4: With `irq_en_i` = 1, `irq_pull_o` becomes 1 about IRQ_US×CLK_MHZ cycles after a fail is detected, before protection takes effect. With `irq_en_i` = 0 it stays 0.
- R5: `irq_pull_o` returns to 0 within a few cycles after `fail_i` goes low or `irq_en_i` goes to 0.
- R6: When not protected, `sram_ce_n_o` equals `host_ce_n_i` in the same cycle. Whenever `rst_pull_o` is 1, `sram_ce_n_o` is 1.
- R7: If the grace period ends while `host_ce_n_i` is 0, protection and reset wait until `host_ce_n_i` is 1, and take effect on the next clock edge.
- R8: If `fail_i` goes high during the power-up time-out, the block returns at once to the protected state. When power returns, the full time-out starts again.
- R9: A low on `pb_n_i` shorter than PB_US×CLK_MHZ cycles is ignored. A low that lasts that long asserts reset and the SRAM block for the full power-up time-out.
- R10: A high `swover_i` forces protection and reset within a few cycles, without waiting for the grace period.
- R11: A fail pulse that ends before the grace period expires causes no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fail_i | input | 1 | Supply below fail threshold (asynchronous) |
| swover_i | input | 1 | Running from backup supply (asynchronous) |
| pb_n_i | input | 1 | Push-button, active low (asynchronous) |
| irq_en_i | input | 1 | Power-fail interrupt enable |
| host_ce_n_i | input | 1 | Host SRAM chip-enable, active low |
| sram_ce_n_o | output | 1 | Guarded SRAM chip-enable, active low |
| rst_pull_o | output | 1 | 1 = drive reset pin low |
| irq_pull_o | output | 1 | 1 = drive interrupt pin low |

## Verification
Assertions check every cycle that the SRAM is blocked whenever reset is driven, and that the interrupt never rises without the enable. They also check that a drain in progress waits for the host chip-enable, that a fail during the time-out goes straight back to protection, that the time-out counter stays in range, and that a qualified button pulse follows a low input. The time-related behaviours can only be shown by the bench scenarios. These are the lengths of the grace period and the time-out, the restart after a brownout, the rejection of short button presses and short fail pulses, the switchover shortcut, and the interrupt clearing.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WARN,
        ST_DRAIN,
        ST_PROT,
        ST_HOLD
    } guard_st_e;

    typedef struct packed {
        logic fail;
        logic swover;
        logic pb_n;
    } guard_in_t;

    function automatic int us_to_cyc(input int mhz, input int us);
        int c;
        c = mhz * us;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int                 WIDTH   = 3,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/pwr_pb_filter.sv
module pwr_pb_filter #(
    parameter int PB_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic pb_n_s,
    output logic pb_ok_o
);
    localparam int CW = $clog2(PB_CYC + 1);
    localparam logic [CW-1:0] PB_LAST = CW'(PB_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          fired_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            pb_ok_o <= 1'b0;
        end else begin
            pb_ok_o <= 1'b0;
            if (pb_n_s) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (!fired_q) begin
                if (cnt_q == PB_LAST) begin
                    pb_ok_o <= 1'b1;
                    fired_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_PB_LOW: assert property (@(posedge clk) disable iff (rst)
        pb_ok_o |-> !$past(pb_n_s)); // R9
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pwr_guard_pkg::*;
#(
    parameter int WP_CYC  = 10000,
    parameter int RST_CYC = 20000000,
    parameter int IRQ_CYC = 2400
) (
    input  logic      clk,
    input  logic      rst,
    input  guard_in_t in_s,
    input  logic      pb_ok,
    input  logic      irq_en_i,
    input  logic      host_ce_n_i,
    output logic      protect_o,
    output logic      irq_o
);
    localparam int MAXC = (WP_CYC > RST_CYC) ? WP_CYC : RST_CYC;
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WP_LAST  = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] IRQ_MARK = CW'(IRQ_CYC);

    guard_st_e     st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          irq_q;
    logic          down;

    assign down = in_s.fail | in_s.swover;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (in_s.swover)
                    st_d = host_ce_n_i ? ST_PROT : ST_DRAIN;
                else if (in_s.fail)
                    st_d = ST_WARN;
                else if (pb_ok)
                    st_d = ST_HOLD;
            end
            ST_WARN: begin
                if (!down)
                    st_d = ST_RUN;
                else if (in_s.swover || cnt_q == WP_LAST)
                    st_d = host_ce_n_i ? ST_PROT : ST_DRAIN;
            end
            ST_DRAIN: if (host_ce_n_i) st_d = ST_PROT;
            ST_PROT:  if (!down) st_d = ST_HOLD;
            ST_HOLD: begin
                if (down)
                    st_d = ST_PROT;
                else if (cnt_q == RST_LAST)
                    st_d = ST_RUN;
            end
            default: st_d = ST_PROT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_PROT;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
            irq_q <= irq_en_i & in_s.fail &
                     (irq_q | (st_q == ST_WARN && cnt_q >= IRQ_MARK));
        end
    end

    assign protect_o = (st_q == ST_PROT) || (st_q == ST_HOLD);
    assign irq_o     = irq_q;

    AST_IRQ_EN: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(irq_en_i)); // R4
    AST_DRAIN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRAIN && !host_ce_n_i) |=> st_q == ST_DRAIN); // R7
    AST_BROWNOUT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD && in_s.fail) |=> st_q == ST_PROT); // R8
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |-> cnt_q <= RST_LAST); // R2
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
    import pwr_guard_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int WP_US   = 100,
    parameter int RST_US  = 200000,
    parameter int IRQ_US  = 24,
    parameter int PB_US   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_i,
    input  logic swover_i,
    input  logic pb_n_i,
    input  logic irq_en_i,
    input  logic host_ce_n_i,
    output logic sram_ce_n_o,
    output logic rst_pull_o,
    output logic irq_pull_o
);
    localparam int WP_CYC  = us_to_cyc(CLK_MHZ, WP_US);
    localparam int RST_CYC = us_to_cyc(CLK_MHZ, RST_US);
    localparam int IRQ_CYC = us_to_cyc(CLK_MHZ, IRQ_US);
    localparam int PB_CYC  = us_to_cyc(CLK_MHZ, PB_US);

    guard_in_t raw_in, in_s;
    logic      pb_ok;
    logic      protect;

    assign raw_in = '{fail: fail_i, swover: swover_i, pb_n: pb_n_i};

    pwr_sync #(
        .WIDTH  ($bits(guard_in_t)),
        .RST_VAL(3'b101)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (in_s)
    );

    pwr_pb_filter #(.PB_CYC(PB_CYC)) u_pb (
        .clk    (clk),
        .rst    (rst),
        .pb_n_s (in_s.pb_n),
        .pb_ok_o(pb_ok)
    );

    pwr_seq #(
        .WP_CYC (WP_CYC),
        .RST_CYC(RST_CYC),
        .IRQ_CYC(IRQ_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_s       (in_s),
        .pb_ok      (pb_ok),
        .irq_en_i   (irq_en_i),
        .host_ce_n_i(host_ce_n_i),
        .protect_o  (protect),
        .irq_o      (irq_pull_o)
    );

    assign rst_pull_o  = protect;
    assign sram_ce_n_o = protect | host_ce_n_i;

    AST_PROT_CE: assert property (@(posedge clk) disable iff (rst)
        rst_pull_o |-> sram_ce_n_o); // R6
endmodule

// File: tb/pwr_guard_test.sv
module pwr_guard_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fail_i = 1'b0, swover_i = 1'b0, pb_n_i = 1'b1;
    logic irq_en_i = 1'b0, host_ce_n_i = 1'b1;
    logic sram_ce_n_o, rst_pull_o, irq_pull_o;
    int   n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    pwr_guard #(
        .CLK_MHZ(1), .WP_US(40), .RST_US(100), .IRQ_US(10), .PB_US(8)
    ) uut (
        .clk(clk), .rst(rst), .fail_i(fail_i), .swover_i(swover_i),
        .pb_n_i(pb_n_i), .irq_en_i(irq_en_i), .host_ce_n_i(host_ce_n_i),
        .sram_ce_n_o(sram_ce_n_o), .rst_pull_o(rst_pull_o),
        .irq_pull_o(irq_pull_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_release();
        wcyc(120);
        chk("R2 released", rst_pull_o, 1'b0);
    endtask

    task automatic t_reset();
        host_ce_n_i = 1'b0;
        wcyc(3);
        chk("R1 rst pull", rst_pull_o, 1'b1);
        chk("R1 ce blocked", sram_ce_n_o, 1'b1);
        chk("R1 irq idle", irq_pull_o, 1'b0);
        rst = 1'b0;
        wcyc(1);
        chk("R1 first cycle", rst_pull_o, 1'b1);
        wcyc(94);
        chk("R2 still held", rst_pull_o, 1'b1);
        chk("R2 still blocked", sram_ce_n_o, 1'b1);
        wcyc(15);
        chk("R2 released", rst_pull_o, 1'b0);
        host_ce_n_i = 1'b1;
    endtask

    task automatic t_pass();
        host_ce_n_i = 1'b0;
        #1 chk("R6 pass low", sram_ce_n_o, 1'b0);
        host_ce_n_i = 1'b1;
        #1 chk("R6 pass high", sram_ce_n_o, 1'b1);
        wcyc(1);
    endtask

    task automatic t_fail_irq();
        irq_en_i = 1'b1;
        fail_i = 1'b1;
        wcyc(8);
        chk("R4 irq not yet", irq_pull_o, 1'b0);
        wcyc(12);
        chk("R4 irq raised", irq_pull_o, 1'b1);
        chk("R3 no reset yet", rst_pull_o, 1'b0);
        wcyc(18);
        host_ce_n_i = 1'b0;
        #1 chk("R3 ce follows in grace", sram_ce_n_o, 1'b0);
        host_ce_n_i = 1'b1;
        wcyc(10);
        chk("R3 reset after delay", rst_pull_o, 1'b1);
        host_ce_n_i = 1'b0;
        #1 chk("R3 ce blocked", sram_ce_n_o, 1'b1);
        host_ce_n_i = 1'b1;
        fail_i = 1'b0;
        wcyc(5);
        chk("R5 irq cleared on restore", irq_pull_o, 1'b0);
        wcyc(45);
        fail_i = 1'b1;
        wcyc(10);
        chk("R8 brownout protected", rst_pull_o, 1'b1);
        fail_i = 1'b0;
        wcyc(95);
        chk("R8 timeout restarted", rst_pull_o, 1'b1);
        wcyc(15);
        chk("R8 released after restart", rst_pull_o, 1'b0);
    endtask

    task automatic t_irq_disable();
        irq_en_i = 1'b1;
        fail_i = 1'b1;
        wcyc(20);
        chk("R4 irq on", irq_pull_o, 1'b1);
        irq_en_i = 1'b0;
        wcyc(2);
        chk("R5 irq cleared by enable", irq_pull_o, 1'b0);
        wcyc(30);
        chk("R4 irq stays off", irq_pull_o, 1'b0);
        chk("R3 protected", rst_pull_o, 1'b1);
        fail_i = 1'b0;
        wait_release();
    endtask

    task automatic t_glitch();
        fail_i = 1'b1;
        wcyc(20);
        fail_i = 1'b0;
        wcyc(60);
        chk("R11 short fail ignored", rst_pull_o, 1'b0);
    endtask

    task automatic t_drain();
        host_ce_n_i = 1'b0;
        fail_i = 1'b1;
        wcyc(60);
        chk("R7 reset waits", rst_pull_o, 1'b0);
        chk("R7 cycle not cut", sram_ce_n_o, 1'b0);
        host_ce_n_i = 1'b1;
        wcyc(2);
        chk("R7 protect after cycle", rst_pull_o, 1'b1);
        host_ce_n_i = 1'b0;
        #1 chk("R7 ce blocked", sram_ce_n_o, 1'b1);
        host_ce_n_i = 1'b1;
        fail_i = 1'b0;
        wait_release();
    endtask

    task automatic t_swover();
        swover_i = 1'b1;
        wcyc(5);
        chk("R10 immediate protect", rst_pull_o, 1'b1);
        swover_i = 1'b0;
        wait_release();
    endtask

    task automatic t_button();
        pb_n_i = 1'b0;
        wcyc(4);
        pb_n_i = 1'b1;
        wcyc(15);
        chk("R9 short press ignored", rst_pull_o, 1'b0);
        pb_n_i = 1'b0;
        wcyc(16);
        chk("R9 press accepted", rst_pull_o, 1'b1);
        pb_n_i = 1'b1;
        wcyc(80);
        chk("R9 held for timeout", rst_pull_o, 1'b1);
        wcyc(30);
        chk("R9 released", rst_pull_o, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pass();
        t_fail_irq();
        t_irq_disable();
        t_glitch();
        t_drain();
        t_swover();
        t_button();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule